// File: doc/BRIEF.md
# Interlaced Raster Timing and Sync Status Generator

This block turns a dot-rate enable into raster position. A dot counter runs across each line and a line counter runs down each frame. When the last line ends the line counter returns to zero, and if interlace is on the field flag flips. A one-cycle frame-start pulse marks the line where the visible frame begins. A status word combines the current line, the field and three video-state bits that come from the position within the line.

Software sets the raster geometry through four small configuration registers behind a single write port. These are frame height, line length, interlace enable, vertical sync height, horizontal sync width and front porch. The back porch is a fixed build parameter. The status bits follow two rule sets. Lines whose parity matches the current field open with a sync pulse and a front porch. Lines of the other parity run active video until the back porch starts.

Top module: `crtc_sync_timer`

## Requirements
- R1: After synchronous reset, `line_o` is 0, `field_o` is 0, `frame_start_o` is 0 and `status_o` is 0. The configuration takes its reset values: total word 0x0270035F, sync-time word 0x07D6A53F, interlace off, front-porch code 0.
- R2: In the total register, selected by `cfg_sel` = 0, bits 25:16 hold (lines per frame − 1) and bits 9:0 hold (dots per line − 1). All other bits are ignored. With reset values a line is 864 dots long and the sync-time word gives 5 vsync lines and a 128-dot hsync.
- R3: The dot position advances only in cycles where `dot_en` is 1. After (dots per line) enabled cycles the dot position returns to 0 and `line_o` steps by one.
- R4: When the last line of the frame ends, `line_o` returns to 0. `field_o` toggles at that point only if interlace is enabled, and it changes at no other time. Interlace is enabled by bit 4 of the sync-config register, selected by `cfg_sel` = 1.
- R5: `frame_start_o` is high for exactly the cycle in which `line_o` first shows line 42, after stepping from line 41.
- R6: `status_o[9:0]` equals `line_o`, and `status_o[10]` equals `field_o`, where 1 means the odd field.
- R7: On a line whose least significant bit equals `field_o`, hsync-off (`status_o[12]`) is set once the dot position is at least 2×(H+1). H is bits 6:0 of the sync-time register, selected by `cfg_sel` = 2.
- R8: On such a line with a line number of at least V, the vsync line count in sync-time bits 11:8, vsync-off (`status_o[13]`) is set. Display-active (`status_o[11]`) is also set once the dot position is at least F+1. F is bits 9:0 of the front-porch register, selected by `cfg_sel` = 3. Below V, both bits are clear.
- R9: On a line of the other parity with a line number of at least V, `status_o[12]` and `status_o[13]` are set. `status_o[11]` is set while the dot position is below (dots per line − BACK_PORCH_DOTS).
- R10: On a line of the other parity below V, only `status_o[12]` is set among bits 13:11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | Dot-rate enable; one dot per high cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 total, 1 sync config, 2 sync time, 3 front porch |
| cfg_wdata | input | 32 | Configuration write data |
| line_o | output | 10 | Current line number |
| field_o | output | 1 | Field flag, 1 = odd |
| frame_start_o | output | 1 | One-cycle pulse on entering line 42 |
| status_o | output | 14 | Sync status word |

## Verification
The raster runs through two whole frames under four geometries. These cover progressive and interlaced scan, an even and an odd frame height, and a dot enable that is either always on or present every other cycle. Every cycle, the outputs are compared against an independent position model. An odd frame height shows whether the field-to-line-parity link is computed from the live flag rather than assumed. Zero and nonzero vsync heights, narrow and wide sync pulses, and front porches on either side of the back-porch threshold separate the four status rule branches from each other. A directed run with reset geometry confirms the 864-dot line and the 128-dot sync edge.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

  typedef enum logic [1:0] {
    SEL_TOTAL     = 2'd0,
    SEL_SYNC_CFG  = 2'd1,
    SEL_SYNC_TIME = 2'd2,
    SEL_FRONT     = 2'd3
  } cfg_sel_e;

  // bit positions inside the configuration words
  localparam int TOT_LINES_LSB = 16;
  localparam int TOT_DOTS_LSB  = 0;
  localparam int ILACE_BIT     = 4;
  localparam int VS_LSB        = 8;
  localparam int VS_W          = 4;
  localparam int HS_LSB        = 0;
  localparam int HS_W          = 7;

endpackage

// File: rtl/crtc_cfg_regs.sv
module crtc_cfg_regs
  import crtc_pkg::*;
#(
  parameter int          LINE_W          = 10,
  parameter int          DOT_W           = 10,
  parameter logic [31:0] TOTAL_RESET     = 32'h0270035F,
  parameter logic [31:0] SYNC_TIME_RESET = 32'h07D6A53F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [31:0]       wdata_i,
  output logic [LINE_W-1:0] lines_m1_o,
  output logic [DOT_W-1:0]  len_m1_o,
  output logic              ilace_o,
  output logic [VS_W-1:0]   vs_lines_o,
  output logic [HS_W-1:0]   hs_code_o,
  output logic [DOT_W-1:0]  fp_code_o
);

  // several write-data bits carry no field; gather them so they are consumed
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_m1_o <= TOTAL_RESET[TOT_LINES_LSB +: LINE_W];
      len_m1_o   <= TOTAL_RESET[TOT_DOTS_LSB +: DOT_W];
      ilace_o    <= 1'b0;
      vs_lines_o <= SYNC_TIME_RESET[VS_LSB +: VS_W];
      hs_code_o  <= SYNC_TIME_RESET[HS_LSB +: HS_W];
      fp_code_o  <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_TOTAL: begin
          lines_m1_o <= wdata_i[TOT_LINES_LSB +: LINE_W];
          len_m1_o   <= wdata_i[TOT_DOTS_LSB +: DOT_W];
        end
        SEL_SYNC_CFG:  ilace_o <= wdata_i[ILACE_BIT];
        SEL_SYNC_TIME: begin
          vs_lines_o <= wdata_i[VS_LSB +: VS_W];
          hs_code_o  <= wdata_i[HS_LSB +: HS_W];
        end
        SEL_FRONT:     fp_code_o <= wdata_i[DOT_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/crtc_raster_counter.sv
module crtc_raster_counter #(
  parameter int LINE_W      = 10,
  parameter int DOT_W       = 10,
  parameter int RETRACE_END = 42
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dot_en_i,
  input  logic [LINE_W-1:0] lines_m1_i,
  input  logic [DOT_W-1:0]  len_m1_i,
  input  logic              ilace_i,
  output logic [LINE_W-1:0] line_q,
  output logic              field_q,
  output logic              frame_q,
  output logic [LINE_W-1:0] nxt_line_o,
  output logic [DOT_W-1:0]  nxt_dot_o,
  output logic              nxt_field_o
);

  localparam logic [LINE_W-1:0] RE_LINE = LINE_W'(RETRACE_END);

  logic [DOT_W-1:0] dot_q;
  logic             end_of_line;
  logic             last_line;
  logic             line_adv;
  logic             nxt_frame;

  always_comb begin
    // ">=" keeps counters bounded if geometry shrinks mid-frame
    end_of_line = (dot_q >= len_m1_i);
    last_line   = (line_q >= lines_m1_i);
    line_adv    = dot_en_i & end_of_line;

    nxt_dot_o   = dot_q;
    nxt_line_o  = line_q;
    nxt_field_o = field_q;
    if (dot_en_i) begin
      nxt_dot_o = end_of_line ? '0 : dot_q + 1'b1;
    end
    if (line_adv) begin
      if (last_line) begin
        nxt_line_o  = '0;
        nxt_field_o = field_q ^ ilace_i;
      end else begin
        nxt_line_o  = line_q + 1'b1;
      end
    end
    nxt_frame = line_adv & ~last_line & (nxt_line_o == RE_LINE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dot_q   <= '0;
      line_q  <= '0;
      field_q <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      dot_q   <= nxt_dot_o;
      line_q  <= nxt_line_o;
      field_q <= nxt_field_o;
      frame_q <= nxt_frame;
    end
  end

endmodule

// File: rtl/crtc_status_enc.sv
module crtc_status_enc
  import crtc_pkg::*;
#(
  parameter int LINE_W          = 10,
  parameter int DOT_W           = 10,
  parameter int BACK_PORCH_DOTS = 108
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic              field_i,
  input  logic [VS_W-1:0]   vs_lines_i,
  input  logic [HS_W-1:0]   hs_code_i,
  input  logic [DOT_W-1:0]  fp_code_i,
  input  logic [DOT_W-1:0]  len_m1_i,
  output logic              act_o,
  output logic              hoff_o,
  output logic              voff_o
);

  // wide enough for dot + back porch and for the doubled sync width
  localparam int EW = (DOT_W + 2 > HS_W + 3) ? DOT_W + 2 : HS_W + 3;

  logic [EW-1:0] dot_x, hs_dots, bp_sum;
  logic          same_par, below_vs, hs_past, fp_past, bp_open;

  always_comb begin
    dot_x    = EW'(dot_i);
    hs_dots  = EW'({hs_code_i, 1'b0}) + EW'(2);
    bp_sum   = dot_x + EW'(BACK_PORCH_DOTS);
    same_par = (line_i[0] == field_i);
    below_vs = (line_i < LINE_W'(vs_lines_i));
    hs_past  = (dot_x >= hs_dots);
    fp_past  = (dot_i > fp_code_i);
    bp_open  = (bp_sum <= EW'(len_m1_i));

    if (same_par) begin
      hoff_o = hs_past;
      voff_o = ~below_vs;
      act_o  = ~below_vs & fp_past;
    end else begin
      hoff_o = 1'b1;
      voff_o = ~below_vs;
      act_o  = ~below_vs & bp_open;
    end
  end

endmodule

// File: rtl/crtc_sync_timer.sv
module crtc_sync_timer
  import crtc_pkg::*;
#(
  parameter int          LINE_W          = 10,
  parameter int          DOT_W           = 10,
  parameter int          RETRACE_END     = 42,
  parameter int          BACK_PORCH_DOTS = 108,
  parameter logic [31:0] TOTAL_RESET     = 32'h0270035F,
  parameter logic [31:0] SYNC_TIME_RESET = 32'h07D6A53F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dot_en,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o,
  output logic              frame_start_o,
  output logic [LINE_W+3:0] status_o
);

  localparam int ST_W = LINE_W + 4;

  logic [LINE_W-1:0] lines_m1, nxt_line;
  logic [DOT_W-1:0]  len_m1, fp_code, nxt_dot;
  logic              ilace, nxt_field;
  logic [VS_W-1:0]   vs_lines;
  logic [HS_W-1:0]   hs_code;
  logic              st_act, st_hoff, st_voff;
  logic [ST_W-1:0]   status_q;

  crtc_cfg_regs #(
    .LINE_W(LINE_W), .DOT_W(DOT_W),
    .TOTAL_RESET(TOTAL_RESET), .SYNC_TIME_RESET(SYNC_TIME_RESET)
  ) u_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we), .sel_i(cfg_sel), .wdata_i(cfg_wdata),
    .lines_m1_o(lines_m1), .len_m1_o(len_m1), .ilace_o(ilace),
    .vs_lines_o(vs_lines), .hs_code_o(hs_code), .fp_code_o(fp_code)
  );

  crtc_raster_counter #(
    .LINE_W(LINE_W), .DOT_W(DOT_W), .RETRACE_END(RETRACE_END)
  ) u_raster (
    .clk(clk), .rst(rst), .dot_en_i(dot_en),
    .lines_m1_i(lines_m1), .len_m1_i(len_m1), .ilace_i(ilace),
    .line_q(line_o), .field_q(field_o), .frame_q(frame_start_o),
    .nxt_line_o(nxt_line), .nxt_dot_o(nxt_dot), .nxt_field_o(nxt_field)
  );

  // status is encoded from next-state position so the register lines up
  // with the counters it describes
  crtc_status_enc #(
    .LINE_W(LINE_W), .DOT_W(DOT_W), .BACK_PORCH_DOTS(BACK_PORCH_DOTS)
  ) u_enc (
    .line_i(nxt_line), .dot_i(nxt_dot), .field_i(nxt_field),
    .vs_lines_i(vs_lines), .hs_code_i(hs_code), .fp_code_i(fp_code),
    .len_m1_i(len_m1),
    .act_o(st_act), .hoff_o(st_hoff), .voff_o(st_voff)
  );

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= {st_voff, st_hoff, st_act, nxt_field, nxt_line};
  end

  assign status_o = status_q;

endmodule

// File: rtl/crtc_sync_checker.sv
module crtc_sync_checker #(
  parameter int LINE_W      = 10,
  parameter int RETRACE_END = 42
) (
  input logic              clk,
  input logic              rst,
  input logic              dot_en,
  input logic [LINE_W-1:0] line_o,
  input logic              field_o,
  input logic              frame_start_o,
  input logic [LINE_W+3:0] status_o
);

  localparam int ACT_B  = LINE_W + 1;
  localparam int VOFF_B = LINE_W + 3;

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(dot_en) |-> ($stable(line_o) && $stable(field_o)));  // R3

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_o) |-> (line_o == LINE_W'($past(line_o) + 1'b1) || line_o == '0));  // R3

  AST_FIELD_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(field_o) |-> (line_o == '0));  // R4

  AST_FRAME_POINT: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> (line_o == LINE_W'(RETRACE_END) &&
                       $past(line_o) == LINE_W'(RETRACE_END - 1)));  // R5

  AST_STATUS_POS: assert property (@(posedge clk) disable iff (rst)
    (status_o[LINE_W-1:0] == line_o) && (status_o[LINE_W] == field_o));  // R6

  AST_ACTIVE_NEEDS_VOFF: assert property (@(posedge clk) disable iff (rst)
    status_o[ACT_B] |-> status_o[VOFF_B]);  // R8

endmodule

bind crtc_sync_timer crtc_sync_checker #(
  .LINE_W(LINE_W), .RETRACE_END(RETRACE_END)
) u_chk (
  .clk(clk), .rst(rst), .dot_en(dot_en), .line_o(line_o),
  .field_o(field_o), .frame_start_o(frame_start_o), .status_o(status_o)
);

// File: tb/tb_crtc_sync_timer.sv
module tb_crtc_sync_timer;

  localparam int CLK_PERIOD = 10;
  localparam int BP_DOTS    = 108;
  localparam int N_VEC      = 4;

  // geometry vectors: lines-1, dots-1, interlace, vsync lines, hsync code,
  // front-porch code, dot enable divider
  localparam int V_LINES[N_VEC] = '{49, 49, 44, 50};
  localparam int V_DOTS [N_VEC] = '{149, 149, 119, 199};
  localparam int V_IL   [N_VEC] = '{0, 1, 1, 1};
  localparam int V_VS   [N_VEC] = '{5, 3, 8, 0};
  localparam int V_HS   [N_VEC] = '{9, 0, 20, 63};
  localparam int V_FP   [N_VEC] = '{30, 0, 60, 100};
  localparam int V_DIV  [N_VEC] = '{1, 1, 2, 1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dot_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [9:0]  line_o;
  logic        field_o;
  logic        frame_start_o;
  logic [13:0] status_o;

  int checks = 0;
  int errors = 0;
  int m_line, m_dot, m_field, m_frame;

  always #(CLK_PERIOD/2) clk = ~clk;

  crtc_sync_timer dut (
    .clk(clk), .rst(rst), .dot_en(dot_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .line_o(line_o),
    .field_o(field_o), .frame_start_o(frame_start_o), .status_o(status_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; dot_en = 1'b0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // expected {vsync-off, hsync-off, active} from the requirements
  function automatic logic [2:0] exp_hi(int line, int dot, int field, int vs,
                                        int hs, int fp, int len_m1);
    logic v, h, a;
    v = 1'b0; h = 1'b0; a = 1'b0;
    if ((line % 2) == field) begin
      h = (dot >= 2 * (hs + 1));
      if (line >= vs) begin
        v = 1'b1;
        a = (dot >= fp + 1);
      end
    end else if (line >= vs) begin
      v = 1'b1; h = 1'b1;
      a = (dot < len_m1 + 1 - BP_DOTS);
    end else begin
      h = 1'b1;
    end
    return {v, h, a};
  endfunction

  task automatic model_step(input int v, input logic en);
    m_frame = 0;
    if (en) begin
      if (m_dot >= V_DOTS[v]) begin
        m_dot = 0;
        if (m_line >= V_LINES[v]) begin
          m_line = 0;
          if (V_IL[v] != 0) m_field = 1 - m_field;
        end else begin
          m_line = m_line + 1;
          if (m_line == 42) m_frame = 1;
        end
      end else begin
        m_dot = m_dot + 1;
      end
    end
  endtask

  task automatic check_all(input int v);
    logic [2:0] e;
    chk("R3 line", line_o, m_line);
    chk("R4 field", field_o, m_field);
    chk("R5 frame pulse", frame_start_o, m_frame);
    chk("R6 status line/field", status_o[10:0], (m_field << 10) | m_line);
    e = exp_hi(m_line, m_dot, m_field, V_VS[v], V_HS[v], V_FP[v], V_DOTS[v]);
    if ((m_line % 2) == m_field) begin
      chk("R7 hsync-off", status_o[12], e[1]);
      chk("R8 vsync-off/active", {status_o[13], status_o[11]}, {e[2], e[0]});
    end else if (m_line >= V_VS[v]) begin
      chk("R9 other-parity bits", status_o[13:11], e);
    end else begin
      chk("R10 other-parity before vsync", status_o[13:11], e);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // directed: reset state and reset geometry
    do_reset();
    @(negedge clk);
    chk("R1 line", line_o, 0);
    chk("R1 field", field_o, 0);
    chk("R1 frame", frame_start_o, 0);
    chk("R1 status", status_o, 0);
    dot_en = 1'b1;
    repeat (127) @(negedge clk);
    chk("R7 default hsync not yet over", status_o[12], 0);
    @(negedge clk);
    chk("R7 default hsync over at dot 128", status_o[12], 1);
    repeat (735) @(negedge clk);
    chk("R2 default line length, dot 863", line_o, 0);
    @(negedge clk);
    chk("R2 default line length, line 1", line_o, 1);
    chk("R10 default vsync lines, status", status_o, 14'h1001);
    dot_en = 1'b0;

    // vector table walk
    for (int v = 0; v < N_VEC; v++) begin
      int ncyc;
      do_reset();
      wr(2'd0, {6'h2A, 10'(V_LINES[v]), 6'h15, 10'(V_DOTS[v])});   // R2 R11
      wr(2'd1, 32'hFFFF_FFE0 | (32'(V_IL[v]) << 4));                // R4
      wr(2'd2, 32'hF00F_F080 | (32'(V_VS[v]) << 8) | 32'(V_HS[v])); // R7
      wr(2'd3, 32'hFFFF_FC00 | 32'(V_FP[v]));                       // R8
      repeat (2) @(negedge clk);
      m_line = 0; m_dot = 0; m_field = 0; m_frame = 0;
      ncyc = (V_LINES[v] + 1) * (V_DOTS[v] + 1) * 2 * V_DIV[v];
      for (int c = 0; c < ncyc; c++) begin
        logic en;
        @(negedge clk);
        check_all(v);
        en = ((c % V_DIV[v]) == V_DIV[v] - 1);
        dot_en = en;
        @(posedge clk);
        model_step(v, en);
      end
      @(negedge clk);
      check_all(v);
      dot_en = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule